// File: doc/BRIEF.md
# Triggered Shutter Timing Controller

This block produces the acquisition-window (shutter) signal for a pixel detector readout. The shutter is driven from one of two sources, picked by a mode input. In software mode the shutter simply tracks a host-held control bit. In trigger mode a rising edge on an asynchronous trigger line starts a timed sequence. The block first waits a programmable number of cycles, then holds the shutter open for a programmable number of cycles. It then waits until the host reports that the frame has been read out.

From the moment a trigger is accepted until the host's readout-done strobe, a busy output tells the trigger source to hold off. Trigger edges that arrive during that time are dropped, and a saturating counter records how many were dropped. A done flag tells the host that the exposure is over and the frame is ready to read. The delay and width settings are captured when a trigger is accepted, so the host may reprogram them for the next frame while the current one runs.

Top module: `shutter_timing_ctrl`

## Requirements
- R1: While reset is asserted, and until a trigger is accepted afterwards, shutter_o, busy_o and done_o are 0 and missed_o is 0 (software mode with sw_shutter_i low).
- R2: With mode_trig_i=1, trig_i passes through a two-flop synchroniser and only its rising edge starts a sequence. If trig_i rises before clock edge 1, busy_o rises at clock edge 3. A trigger held high starts exactly one sequence.
- R3: In trigger mode the shutter opens D clock edges after busy_o rises, where D is delay_i (16-bit cycle count). When D=0 it opens on the same edge as busy_o.
- R4: In trigger mode the shutter stays open for exactly W cycles, where W is width_i. A width of 0 is treated as 1 cycle.
- R5: delay_i and width_i are captured when the trigger is accepted. Changing them during a sequence does not alter that sequence.
- R6: When the shutter closes, done_o rises on the same edge. done_o and busy_o stay high until readout_done_i is sampled high, and both clear on that edge. readout_done_i in any earlier phase has no effect.
- R7: Rising trigger edges seen while busy_o is high do not restart or change the sequence. Each one increments missed_o (16 bits), which saturates at 65535.
- R8: With mode_trig_i=0 (software mode), shutter_o equals sw_shutter_i combinationally. Trigger edges start no sequence and are not counted.
- R9: Asserting rst_ni low asynchronously closes the shutter and clears busy_o, done_o and missed_o, even in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_i | input | 1 | Asynchronous external trigger |
| mode_trig_i | input | 1 | 1 = trigger-started shutter, 0 = software-held shutter |
| delay_i | input | 16 | Cycles from trigger acceptance to shutter opening |
| width_i | input | 16 | Shutter open cycles (0 counts as 1) |
| sw_shutter_i | input | 1 | Software shutter command |
| readout_done_i | input | 1 | Host strobe: frame read out |
| shutter_o | output | 1 | Shutter (acquisition window) |
| busy_o | output | 1 | Sequence in progress, hold off triggers |
| done_o | output | 1 | Exposure finished, awaiting readout |
| missed_o | output | 16 | Saturating count of triggers dropped while busy |

## Verification
The bench aims at the edges of the cycle counts. With a zero delay, a design that waits one cycle too long shows up as a shutter opening late. With a zero width, a design that does not clamp the count produces an empty window, or one that wraps to 65536 cycles. Stray trigger pulses, a readout strobe during the delay and open phases, and register writes during a sequence are all applied mid-sequence. A design that lets any of them in would reopen the shutter, shorten it, or release busy early. A long trigger level and a run of more than 65535 dropped triggers expose a level-sensitive start and a counter that wraps to zero.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_OPEN  = 2'd2,
    ST_WAIT  = 2'd3
  } stc_state_e;
endpackage

// File: rtl/stc_rst_sync.sv
module stc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/stc_trig_sync.sv
module stc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= trig_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/stc_seq.sv
module stc_seq
  import stc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic             readout_done_i,
  output logic             open_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  stc_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] width_q, width_d;
  logic             cnt_en, width_en;

  function automatic logic [CNT_W-1:0] clamp_w(input logic [CNT_W-1:0] w);
    return (w == '0) ? ONE : w;
  endfunction

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    width_d  = width_q;
    cnt_en   = 1'b0;
    width_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (arm_i && start_i) begin
          width_d  = width_i;
          width_en = 1'b1;
          cnt_en   = 1'b1;
          if (delay_i == '0) begin
            state_d = ST_OPEN;
            cnt_d   = clamp_w(width_i);
          end else begin
            state_d = ST_DELAY;
            cnt_d   = delay_i;
          end
        end
      end
      ST_DELAY: begin
        cnt_en = 1'b1;
        if (cnt_q == ONE) begin
          state_d = ST_OPEN;
          cnt_d   = clamp_w(width_q);
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      ST_OPEN: begin
        cnt_en = 1'b1;
        if (cnt_q == ONE) state_d = ST_WAIT;
        else              cnt_d   = cnt_q - ONE;
      end
      ST_WAIT: begin
        if (readout_done_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       width_q <= '0;
    else if (width_en) width_q <= width_d;
  end

  assign open_o = (state_q == ST_OPEN);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_WAIT);
endmodule

// File: rtl/stc_miss_cnt.sv
module stc_miss_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q, count_d;
  logic             count_en;

  always_comb begin
    count_en = inc_i && (count_q != MAXV);
    count_d  = count_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/shutter_timing_ctrl.sv
module shutter_timing_ctrl #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             mode_trig_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic             sw_shutter_i,
  input  logic             readout_done_i,
  output logic             shutter_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] missed_o
);
  logic rst_n_int;
  logic trig_rise;
  logic seq_open;
  logic seq_busy;

  stc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  stc_trig_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .trig_i (trig_i),
    .rise_o (trig_rise)
  );

  stc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_n_int),
    .arm_i          (mode_trig_i),
    .start_i        (trig_rise),
    .delay_i        (delay_i),
    .width_i        (width_i),
    .readout_done_i (readout_done_i),
    .open_o         (seq_open),
    .busy_o         (seq_busy),
    .done_o         (done_o)
  );

  stc_miss_cnt #(.CNT_W(CNT_W)) u_miss (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .inc_i   (trig_rise & mode_trig_i & seq_busy),
    .count_o (missed_o)
  );

  assign busy_o    = seq_busy;
  assign shutter_o = mode_trig_i ? seq_open : sw_shutter_i;
endmodule

// File: rtl/shutter_timing_ctrl_chk.sv
module shutter_timing_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_trig_i,
  input logic             readout_done_i,
  input logic             shutter_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [CNT_W-1:0] missed_o
);
  assert_shut_needs_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_trig_i && shutter_o) |-> busy_o);

  assert_done_needs_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  assert_busy_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(readout_done_i && done_o));

  assert_busy_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(mode_trig_i));

  assert_miss_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(missed_o) |-> (missed_o == $past(missed_o) + CNT_W'(1)));

  assert_miss_sat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (missed_o == {CNT_W{1'b1}}) |=> (missed_o == {CNT_W{1'b1}}));
endmodule

bind shutter_timing_ctrl shutter_timing_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .mode_trig_i    (mode_trig_i),
  .readout_done_i (readout_done_i),
  .shutter_o      (shutter_o),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .missed_o       (missed_o)
);

// File: tb/shutter_timing_ctrl_tb.sv
module shutter_timing_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        trig_i = 1'b0;
  logic        mode_trig_i = 1'b0;
  logic [15:0] delay_i = '0;
  logic [15:0] width_i = '0;
  logic        sw_shutter_i = 1'b0;
  logic        readout_done_i = 1'b0;
  logic        shutter_o, busy_o, done_o;
  logic [15:0] missed_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  shutter_timing_ctrl u_dut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .trig_i         (trig_i),
    .mode_trig_i    (mode_trig_i),
    .delay_i        (delay_i),
    .width_i        (width_i),
    .sw_shutter_i   (sw_shutter_i),
    .readout_done_i (readout_done_i),
    .shutter_o      (shutter_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .missed_o       (missed_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    trig_i = 1'b0;
    readout_done_i = 1'b0;
    wait_cyc(2);
    rst_ni = 1'b1;
    wait_cyc(4);
  endtask

  task automatic readout();
    readout_done_i = 1'b1;
    @(negedge clk_i);
    readout_done_i = 1'b0;
    chk(!busy_o && !done_o, "R6 release", {busy_o, done_o}, 0);
  endtask

  // One trigger sequence; noise adds stray triggers, early readout strobes
  // and register rewrites after acceptance.
  task automatic run_seq(input int d, input int w, input bit noise, input string tag);
    int wc = (w == 0) ? 1 : w;
    int fb = -1, fs = -1, fd = -1, ns = 0;
    logic [15:0] m0;
    m0 = missed_o;
    delay_i = 16'(d);
    width_i = 16'(w);
    trig_i  = 1'b1;
    for (int i = 1; i <= d + wc + 12; i++) begin
      @(negedge clk_i);
      if (busy_o && fb < 0) fb = i;
      if (shutter_o) begin
        if (fs < 0) fs = i;
        ns++;
      end
      if (done_o && fd < 0) fd = i;
      if (i == 1) trig_i = 1'b0;
      if (noise) begin
        if (i == 4) begin
          delay_i = 16'(d + 7);
          width_i = 16'(w + 9);
          trig_i = 1'b1;
          readout_done_i = 1'b1;
        end
        if (i == 5) begin trig_i = 1'b0; readout_done_i = 1'b0; end
        if (i == 6) trig_i = 1'b1;
        if (i == 7) trig_i = 1'b0;
        if (i == 3 + d + 1) readout_done_i = 1'b1;
        if (i == 3 + d + 2) readout_done_i = 1'b0;
      end
    end
    chk(fb == 3, {"R2 busy edge ", tag}, fb, 3);
    chk(fs == 3 + d, {"R3 open edge ", tag}, fs, 3 + d);
    chk(ns == wc, {"R4 open cycles ", tag}, ns, wc);
    chk(fd == 3 + d + wc, {"R6 done edge ", tag}, fd, 3 + d + wc);
    chk(busy_o && done_o, {"R6 held ", tag}, busy_o, 1);
    if (noise) begin
      chk(missed_o == m0 + 16'd2, {"R7 missed count ", tag}, missed_o, m0 + 2);
    end
    readout();
    delay_i = '0;
    width_i = '0;
  endtask

  task automatic t_reset_state();
    rst_ni = 1'b0;
    mode_trig_i = 1'b0;
    #5;
    chk(!shutter_o && !busy_o && !done_o && missed_o == 0, "R1 in reset",
        {shutter_o, busy_o, done_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    wait_cyc(4);
    chk(!shutter_o && !busy_o && !done_o && missed_o == 0, "R1 after reset",
        {shutter_o, busy_o, done_o}, 0);
    mode_trig_i = 1'b1;
  endtask

  task automatic t_basic();
    run_seq(0, 1, 1'b0, "d0 w1");
    run_seq(0, 0, 1'b0, "w0");
    run_seq(1, 3, 1'b0, "d1 w3");
    run_seq(17, 40, 1'b0, "d17 w40");
  endtask

  task automatic t_noise();
    run_seq(5, 10, 1'b1, "R5 noise");
  endtask

  task automatic t_held_trigger();
    logic [15:0] m0;
    int extra = 0;
    m0 = missed_o;
    delay_i = '0;
    width_i = 16'd2;
    trig_i = 1'b1;
    wait_cyc(6);
    chk(done_o, "R2 held done", done_o, 1);
    readout_done_i = 1'b1;
    @(negedge clk_i);
    readout_done_i = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (busy_o) extra++;
    end
    chk(extra == 0, "R2 level restart", extra, 0);
    chk(missed_o == m0, "R2 level count", missed_o, m0);
    trig_i = 1'b0;
    wait_cyc(3);
  endtask

  task automatic t_sw_mode();
    logic [15:0] m0;
    int bz = 0;
    m0 = missed_o;
    mode_trig_i = 1'b0;
    sw_shutter_i = 1'b1;
    #1;
    chk(shutter_o == 1'b1, "R8 follow high", shutter_o, 1);
    trig_i = 1'b1;
    @(negedge clk_i);
    trig_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      if (busy_o) bz++;
    end
    chk(bz == 0, "R8 trigger ignored", bz, 0);
    chk(missed_o == m0, "R8 not counted", missed_o, m0);
    sw_shutter_i = 1'b0;
    #1;
    chk(shutter_o == 1'b0, "R8 follow low", shutter_o, 0);
    @(negedge clk_i);
    mode_trig_i = 1'b1;
    wait_cyc(2);
  endtask

  task automatic t_async_reset();
    delay_i = '0;
    width_i = 16'd50;
    trig_i = 1'b1;
    @(negedge clk_i);
    trig_i = 1'b0;
    wait_cyc(6);
    chk(shutter_o, "R9 open before", shutter_o, 1);
    #3;
    rst_ni = 1'b0;
    #1;
    chk(!shutter_o && !busy_o && !done_o, "R9 async close",
        {shutter_o, busy_o, done_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    wait_cyc(4);
    chk(!busy_o && missed_o == 0, "R9 idle after", busy_o, 0);
  endtask

  task automatic t_saturate();
    do_reset();
    delay_i = '0;
    width_i = 16'd1;
    trig_i = 1'b1;
    @(negedge clk_i);
    trig_i = 1'b0;
    wait_cyc(4);
    chk(done_o, "R7 sat setup", done_o, 1);
    for (int i = 0; i < 65540; i++) begin
      trig_i = 1'b1;
      @(negedge clk_i);
      trig_i = 1'b0;
      @(negedge clk_i);
    end
    wait_cyc(4);
    chk(missed_o == 16'hFFFF, "R7 saturate", missed_o, 65535);
    chk(busy_o && done_o && !shutter_o, "R7 sequence kept", busy_o, 1);
    readout();
  endtask

  initial begin
    t_reset_state();
    t_basic();
    t_noise();
    t_held_trigger();
    t_sw_mode();
    t_async_reset();
    t_saturate();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule